// File: doc/BRIEF.md
# Two-Channel DAC Input Stage with Interleave Demultiplexer

This block is the digital front end of a two-channel 12-bit digital-to-analog converter. It takes parallel sample words from two data ports, together with per-channel write and clock strobes, and delivers two core words (I and Q), each with a one-cycle update strobe, to the converter cores. All strobes are level inputs sampled by one fast reference clock `clk`; the block finds their edges itself.

In dual-bus mode the two channels are independent. A rising write strobe captures a port word into that channel's input latch, and the channel clock then carries it through the converter latch and a short pipeline to the core. In interleaved mode only port A carries data, with I and Q words alternating at twice the core rate. The channel-B write pin becomes the I/Q select, the channel-A pins become the shared write and clock, and the channel-B clock pin becomes a phase-alignment input. The shared clock is halved to form the core update clock. While the phase-alignment input is high, the halved clock is held low, so the pairing of I and Q words at the core is deterministic.

A sleep input freezes both core words and silences the update strobes. The input latches keep taking writes while asleep.

Top module: `dacfe_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `core_i`, `core_q`, `upd_i` and `upd_q` are all zero.
- R2: With `mode_dual`=1, a rising edge of `wr_a` captures `port_a` into channel I's input latch, and a rising edge of `wr_b` captures `port_b` into channel Q's input latch. Activity on one channel never changes the other channel's core word.
- R3: With `mode_dual`=1, every rising edge of a channel clock (`ck_a` for I, `ck_b` for Q) advances that channel's pipeline and raises its update strobe for exactly one `clk` cycle. A word is on the core output after the fourth channel-clock rise detected later than the cycle in which its write rise is detected. A clock rise that coincides with the write does not count. The core word changes only in a cycle where its update strobe is high.
- R4: A channel clock that rises one or more `clk` cycles after the write rise still gives the same four-rise latency.
- R5: With `mode_dual`=0, a rising edge of `wr_a` captures `port_a` into the I latch when `wr_b` (select) is 1, or into the Q latch when it is 0. The latch not selected keeps its value. `port_b` has no effect in this mode.
- R6: With `mode_dual`=0, the I and Q latch contents move to the converter latches only on a falling edge of `wr_a`. While `wr_a` stays high, a newly captured word does not reach the core.
- R7: With `mode_dual`=0, the core update clock is `ck_a` divided by two. While `ck_b` (phase align) is 1 there are no core updates. After `ck_b` returns to 0, the 1st, 3rd, 5th and later odd `ck_a` rises are core updates. `upd_i` and `upd_q` are always equal in this mode.
- R8: With `mode_dual`=0, an I/Q pair moved to the converter latches appears together on `core_i` and `core_q` at the fourth core update after the move.
- R9: While `sleep`=1, `core_i` and `core_q` hold their values and both update strobes stay 0. Writes during sleep still reach the input latches and flow out after `sleep` returns to 0.
- R10: Words are plain offset binary, bit 11 being the MSB. Codes 0x000, 0x800 and 0xFFF reach the core unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock sampling every strobe |
| rst | input | 1 | Synchronous active-high reset |
| mode_dual | input | 1 | 1 = dual-bus, 0 = interleaved; tie high by default |
| sleep | input | 1 | 1 = power-down hold; tie low by default |
| port_a | input | 12 | Data port A (I in dual mode, I/Q in interleaved) |
| port_b | input | 12 | Data port B (Q in dual mode, unused in interleaved) |
| wr_a | input | 1 | Channel I write; shared write in interleaved mode |
| wr_b | input | 1 | Channel Q write; I/Q select in interleaved mode |
| ck_a | input | 1 | Channel I clock; shared clock in interleaved mode |
| ck_b | input | 1 | Channel Q clock; phase align in interleaved mode |
| core_i | output | 12 | Word to the I converter core |
| core_q | output | 12 | Word to the Q converter core |
| upd_i | output | 1 | One-cycle update strobe for `core_i` |
| upd_q | output | 1 | One-cycle update strobe for `core_q` |

## Verification
The bench builds the block with its defaults, a 12-bit word and a four-stage latency. A twelve-pulse stream therefore covers pipeline fill, steady state and drain, and the extreme and midscale codes fit one check each. In interleaved mode the counts of shared-clock pulses are chosen so that the odd/even phase of the divider decides whether a pair has arrived. Holding the write high across several core updates separates capture on the write rise from transfer on its fall.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  // Bus organisation selected by the mode input.
  typedef enum logic {
    BUS_INTERLEAVED = 1'b0,
    BUS_DUAL        = 1'b1
  } bus_mode_e;

  // Bit positions of the strobe vector fed to the edge finder.
  localparam int STB_WR_A  = 0;
  localparam int STB_WR_B  = 1;
  localparam int STB_CK_A  = 2;
  localparam int STB_CK_B  = 3;
  localparam int NUM_STB   = 4;
  localparam int NUM_CHAN  = 2;
endpackage

// File: rtl/dacfe_edge.sv
// Rising-edge finder for a vector of level strobes sampled by clk.
module dacfe_edge #(
  parameter int           N    = 1,
  parameter logic [N-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= IDLE;
    else     lvl_q <= lvl;
  end

  for (genvar b = 0; b < N; b++) begin : g_bit
    assign rise[b] = lvl[b] & ~lvl_q[b];
  end
endmodule

// File: rtl/dacfe_latch.sv
// Input latches plus the interleave demultiplexer and transfer stage.
module dacfe_latch #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dual,
  input  logic          ld_a,
  input  logic          ld_b,
  input  logic          xfer_en,
  input  logic          sel,
  input  logic [DW-1:0] port_a,
  input  logic [DW-1:0] port_b,
  output logic [DW-1:0] src_i,
  output logic [DW-1:0] src_q
);
  logic [DW-1:0] hold_i, hold_q, nxt_i, nxt_q;
  logic [DW-1:0] xfer_i, xfer_q;

  always_comb begin
    nxt_i = hold_i;
    nxt_q = hold_q;
    if (dual) begin
      if (ld_a) nxt_i = port_a;
      if (ld_b) nxt_q = port_b;
    end else if (ld_a) begin
      // The latch not selected is fed back with its own value.
      nxt_i = sel ? port_a : hold_i;
      nxt_q = sel ? hold_q : port_a;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_i <= '0;
      hold_q <= '0;
      xfer_i <= '0;
      xfer_q <= '0;
    end else begin
      hold_i <= nxt_i;
      hold_q <= nxt_q;
      if (!dual && xfer_en) begin
        xfer_i <= hold_i;
        xfer_q <= hold_q;
      end
    end
  end

  assign src_i = dual ? hold_i : xfer_i;
  assign src_q = dual ? hold_q : xfer_q;
endmodule

// File: rtl/dacfe_clkdiv.sv
// Halves the shared clock; the phase input forces the halved clock low.
module dacfe_clkdiv (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ck_rise,
  input  logic hold,
  output logic core_rise
);
  logic phase;

  always_ff @(posedge clk) begin
    if (rst || !en || hold) phase <= 1'b0;
    else if (ck_rise)       phase <= ~phase;
  end

  assign core_rise = en & ~hold & ck_rise & ~phase;
endmodule

// File: rtl/dacfe_pipe.sv
// Converter latch followed by the remaining latency stages of one channel.
module dacfe_pipe #(
  parameter int DW  = 12,
  parameter int LAT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          upd
);
  logic [LAT-1:0][DW-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
      upd <= 1'b0;
    end else begin
      upd <= adv;
      if (adv) begin
        stg[0] <= din;
        for (int i = 1; i < LAT; i++) stg[i] <= stg[i-1];
      end
    end
  end

  assign dout = stg[LAT-1];
endmodule

// File: rtl/dacfe_top.sv
module dacfe_top
  import dacfe_pkg::*;
#(
  parameter int DW  = 12,
  parameter int LAT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_dual,
  input  logic          sleep,
  input  logic [DW-1:0] port_a,
  input  logic [DW-1:0] port_b,
  input  logic          wr_a,
  input  logic          wr_b,
  input  logic          ck_a,
  input  logic          ck_b,
  output logic [DW-1:0] core_i,
  output logic [DW-1:0] core_q,
  output logic          upd_i,
  output logic          upd_q
);
  localparam int NCH = NUM_CHAN;

  logic [NUM_STB-1:0]         stb, rise;
  logic                       wr_fall;
  logic                       core_rise;
  logic                       dual;
  logic [NCH-1:0][DW-1:0]     src, dout;
  logic [NCH-1:0]             adv, upd;

  assign dual = (bus_mode_e'(mode_dual) == BUS_DUAL);

  assign stb[STB_WR_A] = wr_a;
  assign stb[STB_WR_B] = wr_b;
  assign stb[STB_CK_A] = ck_a;
  assign stb[STB_CK_B] = ck_b;

  dacfe_edge #(.N(NUM_STB)) u_edge (
    .clk (clk), .rst (rst), .lvl (stb), .rise (rise)
  );

  // Falling write edge found as the rise of the inverted strobe.
  dacfe_edge #(.N(1), .IDLE(1'b1)) u_wr_fall (
    .clk (clk), .rst (rst), .lvl (~wr_a), .rise (wr_fall)
  );

  dacfe_latch #(.DW(DW)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .dual    (dual),
    .ld_a    (rise[STB_WR_A]),
    .ld_b    (rise[STB_WR_B]),
    .xfer_en (wr_fall),
    .sel     (wr_b),
    .port_a  (port_a),
    .port_b  (port_b),
    .src_i   (src[0]),
    .src_q   (src[1])
  );

  dacfe_clkdiv u_div (
    .clk       (clk),
    .rst       (rst),
    .en        (~dual),
    .ck_rise   (rise[STB_CK_A]),
    .hold      (ck_b),
    .core_rise (core_rise)
  );

  assign adv[0] = (dual ? rise[STB_CK_A] : core_rise) & ~sleep;
  assign adv[1] = (dual ? rise[STB_CK_B] : core_rise) & ~sleep;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dacfe_pipe #(.DW(DW), .LAT(LAT)) u_pipe (
      .clk  (clk),
      .rst  (rst),
      .adv  (adv[c]),
      .din  (src[c]),
      .dout (dout[c]),
      .upd  (upd[c])
    );
  end

  assign core_i = dout[0];
  assign core_q = dout[1];
  assign upd_i  = upd[0];
  assign upd_q  = upd[1];
endmodule

// File: rtl/dacfe_chk.sv
module dacfe_chk #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          mode_dual,
  input logic          sleep,
  input logic          ck_b,
  input logic [DW-1:0] core_i,
  input logic [DW-1:0] core_q,
  input logic          upd_i,
  input logic          upd_q
);
  // R1: outputs cleared on the cycle after reset
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (core_i == '0 && core_q == '0 && !upd_i && !upd_q));

  // R3: a core word only moves together with its strobe
  p_change_needs_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(core_i) |-> upd_i);

  // R3: strobes last a single cycle
  p_strobe_single_r3: assert property (@(posedge clk) disable iff (rst)
    upd_q |=> !upd_q);

  // R7: in interleaved mode both channels update together
  p_pair_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(mode_dual) |-> (upd_i == upd_q));

  // R7: phase align high stops core updates
  p_phase_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!mode_dual && ck_b) |=> !upd_i);

  // R9: sleep freezes both core words and silences strobes
  p_sleep_hold_r9: assert property (@(posedge clk) disable iff (rst)
    sleep |=> ($stable(core_i) && $stable(core_q) && !upd_i && !upd_q));
endmodule

bind dacfe_top dacfe_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode_dual (mode_dual),
  .sleep     (sleep),
  .ck_b      (ck_b),
  .core_i    (core_i),
  .core_q    (core_q),
  .upd_i     (upd_i),
  .upd_q     (upd_q)
);

// File: tb/dacfe_top_tb.sv
`timescale 1ns/1ps
module dacfe_top_tb;
  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_dual = 1'b1;
  logic          sleep = 1'b0;
  logic [DW-1:0] port_a = '0;
  logic [DW-1:0] port_b = '0;
  logic          wr_a = 1'b0, wr_b = 1'b0, ck_a = 1'b0, ck_b = 1'b0;
  logic [DW-1:0] core_i, core_q;
  logic          upd_i, upd_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  dacfe_top u_dut (
    .clk (clk), .rst (rst), .mode_dual (mode_dual), .sleep (sleep),
    .port_a (port_a), .port_b (port_b),
    .wr_a (wr_a), .wr_b (wr_b), .ck_a (ck_a), .ck_b (ck_b),
    .core_i (core_i), .core_q (core_q), .upd_i (upd_i), .upd_q (upd_q)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic dual);
    rst = 1'b1; mode_dual = dual; sleep = 1'b0;
    wr_a = 0; wr_b = 0; ck_a = 0; ck_b = 0; port_a = '0; port_b = '0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
  endtask

  // One channel-I clock pulse, optionally with a coincident write.
  task automatic pulse_a(input logic do_wr, input logic [DW-1:0] d, output logic ui, output logic uq);
    port_a = d; wr_a = do_wr; ck_a = 1'b1;
    tick();
    ui = upd_i; uq = upd_q;
    wr_a = 1'b0; ck_a = 1'b0;
    tick();
  endtask

  // Interleaved write of one word with the given select.
  task automatic il_write(input logic s, input logic [DW-1:0] d);
    port_a = d; port_b = ~d; wr_b = s; wr_a = 1'b1;
    tick();
    wr_a = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    rst = 1'b1; repeat (2) tick();
    chk("R1 core_i in reset", core_i, 0);
    chk("R1 core_q in reset", core_q, 0);
    chk("R1 strobes in reset", {upd_i, upd_q}, 0);
    rst = 1'b0; tick();
    chk("R1 core_i after reset", core_i, 0);
  endtask

  task automatic t_dual_stream();
    logic [DW-1:0] vals [8] = '{12'h800, 12'hFFF, 12'h000, 12'h123,
                                12'hABC, 12'h7FF, 12'h001, 12'hFFE};
    logic ui, uq;
    do_reset(1'b1);
    for (int k = 0; k < 12; k++) begin
      logic [DW-1:0] exp;
      pulse_a(k < 8, (k < 8) ? vals[k] : 12'h5A5, ui, uq);
      exp = (k < 4) ? '0 : vals[(k - 4 > 7) ? 7 : k - 4];
      chk($sformatf("R3 R10 stream core_i k=%0d", k), core_i, exp);
      chk("R3 strobe on clock rise", ui, 1);
      chk("R2 channel Q untouched", {uq, core_q}, 0);
    end
  endtask

  task automatic t_dual_b();
    do_reset(1'b1);
    port_a = 12'hEEE;
    for (int k = 0; k < 5; k++) begin
      port_b = (k == 0) ? 12'h5A5 : 12'h0F0;
      wr_b = (k == 0); ck_b = 1'b1;
      tick();
      chk("R3 channel Q strobe", upd_q, 1);
      wr_b = 1'b0; ck_b = 1'b0;
      tick();
      if (k == 3) chk("R2 core_q before fourth rise", core_q, 0);
    end
    chk("R2 core_q from port_b", core_q, 12'h5A5);
    chk("R2 channel I untouched", core_i, 0);
  endtask

  task automatic t_dual_late_clock();
    logic ui, uq;
    do_reset(1'b1);
    port_a = 12'h3A7; wr_a = 1'b1;
    tick();
    wr_a = 1'b0; port_a = 12'h111; ck_a = 1'b1;
    tick();
    ck_a = 1'b0;
    tick();
    chk("R4 after first late rise", core_i, 0);
    pulse_a(1'b0, 12'h222, ui, uq);
    pulse_a(1'b0, 12'h333, ui, uq);
    chk("R4 after third rise", core_i, 0);
    pulse_a(1'b0, 12'h444, ui, uq);
    chk("R4 late clock latency", core_i, 12'h3A7);
  endtask

  task automatic t_interleaved();
    logic ui, uq;
    do_reset(1'b0);
    ck_b = 1'b1;
    for (int k = 0; k < 3; k++) begin
      pulse_a(1'b0, 12'h000, ui, uq);
      chk("R7 no update while phase align high", {ui, uq}, 0);
    end
    ck_b = 1'b0; tick();
    il_write(1'b1, 12'h3C1);
    il_write(1'b0, 12'h9E7);
    for (int k = 1; k <= 7; k++) begin
      pulse_a(1'b0, 12'h000, ui, uq);
      chk($sformatf("R7 odd pulse updates k=%0d", k), ui, k % 2);
      chk("R7 strobes paired", uq, ui);
      if (k == 5) chk("R8 pair not yet out", {core_i, core_q}, 0);
    end
    chk("R8 I word after fourth update", core_i, 12'h3C1);
    chk("R5 Q word, port_b ignored", core_q, 12'h9E7);
    // Capture a new I word but hold the write high: no transfer.
    port_a = 12'h111; port_b = 12'h222; wr_b = 1'b1; wr_a = 1'b1;
    tick();
    port_a = 12'h000;
    for (int k = 0; k < 8; k++) begin
      ck_a = 1'b1; tick(); ck_a = 1'b0; tick();
    end
    chk("R6 no transfer while write high", core_i, 12'h3C1);
    wr_a = 1'b0; tick();
    for (int k = 0; k < 8; k++) pulse_a(1'b0, 12'h000, ui, uq);
    chk("R6 transfer on write fall", core_i, 12'h111);
    chk("R5 unselected Q recirculated", core_q, 12'h9E7);
  endtask

  task automatic t_sleep();
    logic ui, uq;
    do_reset(1'b1);
    for (int k = 0; k < 5; k++) pulse_a(1'b1, 12'h101 + 12'(k), ui, uq);
    chk("R9 before sleep", core_i, 12'h101);
    sleep = 1'b1;
    pulse_a(1'b1, 12'h2AA, ui, uq);
    chk("R9 strobe silent in sleep", ui, 0);
    pulse_a(1'b1, 12'h2BB, ui, uq);
    chk("R9 core held in sleep", core_i, 12'h101);
    sleep = 1'b0; tick();
    pulse_a(1'b0, 12'h000, ui, uq);
    chk("R9 pipeline resumes", core_i, 12'h102);
    repeat (3) pulse_a(1'b0, 12'h000, ui, uq);
    chk("R9 sleep write kept in latch", core_i, 12'h2BB);
  endtask

  initial begin
    repeat (2) tick();
    t_reset();
    t_dual_stream();
    t_dual_b();
    t_dual_late_clock();
    t_interleaved();
    t_sleep();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20ns * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule